// File: doc/BRIEF.md
# Serial Peripheral Master with Selectable Clock Formats

This block drives one serial peripheral as bus master. When a caller offers a word while the block is ready, the block pulls its active-low select low. It then shifts the word out most significant bit first while it shifts the same number of bits in from the peripheral. After that it releases the select and waits for a programmable idle gap. When the gap ends it hands back the received word with a one-cycle done pulse.

The configuration inputs are static between frames and are captured when a frame is accepted. They set the resting level of the serial clock and which clock edge launches data and which captures it. A late-capture option moves the input sample point one system clock after the normal capture edge, which gives slow peripherals extra time to drive data. The frame length runs from 4 to 16 bits. The length of one serial clock half-period, in system clocks, is also set here. The idle gap is an odd factor times a power of two.

Top module: `spi_fmt_master`

## Requirements
- R1: After reset `ready`=1, `cs_n`=1 and `done`=0. While no frame is in progress, `sclk` rests at the level of `cfg_cpol`, following it one cycle later, and during the idle gap it stays at the captured polarity.
- R2: A `start` sampled while `ready`=1 is accepted. In the next cycle `cs_n`=0 and `ready`=0. The word, length, formats, half-period and gap codes are captured at that edge.
- R3: With half-period H (`cfg_half`, at least 2) and length L, the first `sclk` edge comes H cycles after `cs_n` falls. Later edges follow every H cycles, a frame has exactly 2L edges, and `cs_n` rises H cycles after the last edge with `sclk` back at its resting level.
- R4: With `cfg_cpha`=0, bit L-1 of the word is on `mosi` as soon as `cs_n` falls. Input is captured on edges 1, 3, 5, … and `mosi` changes only on edges 2, 4, … .
- R5: With `cfg_cpha`=1, `mosi` takes each next bit on edges 1, 3, 5, … and input is captured on edges 2, 4, … .
- R6: `cfg_len` L (4..16) sets the frame length. Bits L-1 down to 0 of `tx_word` go out in that order. `rx_word` holds the L captured bits with the first one at bit L-1, and its upper bits are zero.
- R7: With `cfg_late`=1, `miso` is sampled one system clock after each capture edge rather than at it.
- R8: `done` rises exactly F·2^(S+1) cycles after `cs_n` rises. S is `cfg_scl` and F is 1, 3, 5 or 7 for `cfg_pre` codes 0, 1, 2, 3; codes 1 and 14 give 98304 cycles.
- R9: `done` is high for one cycle. `ready` returns high in that same cycle, and `rx_word` is valid then and holds until the next `done`.
- R10: A `start` while `ready`=0 is ignored. It changes neither the frame in flight nor the captured configuration, and it starts no later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Resting level of the serial clock |
| cfg_cpha | input | 1 | 0: first bit driven before first edge; 1: driven on first edge |
| cfg_late | input | 1 | Late input capture, one system clock after the capture edge |
| cfg_half | input | HALF_W | Serial clock half-period in system clocks (at least 2) |
| cfg_len | input | LEN_W | Frame length in bits, 4..MAX_BITS |
| cfg_pre | input | PRE_W | Gap odd-factor code |
| cfg_scl | input | SCL_W | Gap power-of-two code |
| start | input | 1 | Frame request |
| tx_word | input | MAX_BITS | Word to send, right aligned |
| miso | input | 1 | Serial data from the peripheral |
| ready | output | 1 | Block can accept a frame |
| done | output | 1 | One-cycle pulse at the end of the idle gap |
| rx_word | output | MAX_BITS | Received word, right aligned |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low peripheral select |
| mosi | output | 1 | Serial data to the peripheral |

## Verification
A wrong half-period counter or edge counter shows within one half-period as a misplaced `sclk` edge, or as a frame with the wrong edge count. A swapped launch and capture decision corrupts the received word and the bits seen on `mosi` at capture edges in the same frame. A late-capture path that samples too early is exposed by a peripheral model that changes `miso` just after each capture edge, so a classic sample gets stale data. A gap counter that loads or decrements wrongly shifts the `done` edge by a measurable number of cycles, and this is checked even for a 98304-cycle gap.

// File: rtl/spi_fmt_pkg.sv
package spi_fmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } spi_state_e;

  // odd gap factor for a prescaler code: 0->1, 1->3, 2->5, 3->7
  function automatic logic [2:0] pre_factor(input logic [1:0] code);
    return {code, 1'b1};
  endfunction

endpackage

// File: rtl/spi_fmt_gap.sv
module spi_fmt_gap #(
  parameter int PRE_W = 2,
  parameter int SCL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PRE_W-1:0] pre,
  input  logic [SCL_W-1:0] scl,
  output logic             expired
);
  import spi_fmt_pkg::*;

  localparam int GAP_W = (1 << SCL_W) + PRE_W + 1;

  logic [GAP_W-1:0] span;
  logic [GAP_W-1:0] cnt;
  logic             run;

  always_comb begin
    span = (GAP_W'(pre_factor(pre)) << 1) << scl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= span - 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R8: the shortest gap is two cycles, so expiry never follows a load at once
  a_r8_gap_not_immediate: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired);
  // R8: expiry is a single event per load
  a_r8_gap_single: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);

endmodule

// File: rtl/spi_fmt_shift.sv
module spi_fmt_shift #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_word,
  input  logic [LEN_W-1:0]    len,
  input  logic                pre_drive,
  input  logic                launch,
  input  logic                capture,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rx_data
);

  logic [MAX_BITS-1:0] tx_sr;
  logic [MAX_BITS-1:0] aligned;
  logic [LEN_W-1:0]    pad;

  always_comb begin
    pad     = LEN_W'(MAX_BITS) - len;
    aligned = load_word << pad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_data <= '0;
      mosi    <= 1'b0;
    end else if (load) begin
      rx_data <= '0;
      if (pre_drive) begin
        mosi  <= aligned[MAX_BITS-1];
        tx_sr <= aligned << 1;
      end else begin
        tx_sr <= aligned;
      end
    end else begin
      if (launch) begin
        mosi  <= tx_sr[MAX_BITS-1];
        tx_sr <= tx_sr << 1;
      end
      if (capture) rx_data <= {rx_data[MAX_BITS-2:0], miso};
    end
  end

  // R6: a new frame starts with an empty receive register
  a_r6_rx_cleared: assert property (@(posedge clk) disable iff (rst)
    load |=> rx_data == '0);

endmodule

// File: rtl/spi_fmt_master.sv
module spi_fmt_master #(
  parameter int MAX_BITS = 16,
  parameter int HALF_W   = 8,
  parameter int PRE_W    = 2,
  parameter int SCL_W    = 4,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_late,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [PRE_W-1:0]    cfg_pre,
  input  logic [SCL_W-1:0]    cfg_scl,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                miso,
  output logic                ready,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi
);
  import spi_fmt_pkg::*;

  localparam int EDGE_W = LEN_W + 1;

  spi_state_e          state;
  logic [HALF_W-1:0]   hcnt;
  logic [EDGE_W-1:0]   ecnt;
  logic                cpol_q, cpha_q, late_q;
  logic [HALF_W-1:0]   half_q;
  logic [LEN_W-1:0]    len_q;
  logic [PRE_W-1:0]    pre_q;
  logic [SCL_W-1:0]    scl_q;
  logic                cap_late;
  logic [MAX_BITS-1:0] rx_data;
  logic                gap_exp;

  logic              accept, tick, edge_now, last_edge, odd;
  logic              cap_now, launch_now, gap_load, cap_sel;
  logic [EDGE_W-1:0] enext;

  always_comb begin
    accept     = ready && start;
    tick       = (hcnt == '0);
    enext      = ecnt + 1'b1;
    odd        = enext[0];
    last_edge  = (enext == {len_q, 1'b0});
    edge_now   = (state == ST_SHIFT) && tick;
    cap_now    = edge_now && (odd ^ cpha_q);
    launch_now = edge_now && (cpha_q ? odd : (!odd && !last_edge));
    gap_load   = (state == ST_TRAIL) && tick;
    cap_sel    = late_q ? cap_late : cap_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ready    <= 1'b1;
      done     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      hcnt     <= '0;
      ecnt     <= '0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      late_q   <= 1'b0;
      half_q   <= '0;
      len_q    <= '0;
      pre_q    <= '0;
      scl_q    <= '0;
      rx_word  <= '0;
      cap_late <= 1'b0;
    end else begin
      done     <= 1'b0;
      cap_late <= cap_now;
      case (state)
        ST_IDLE: begin
          sclk <= cfg_cpol;
          if (accept) begin
            cpol_q <= cfg_cpol;
            cpha_q <= cfg_cpha;
            late_q <= cfg_late;
            half_q <= cfg_half;
            len_q  <= cfg_len;
            pre_q  <= cfg_pre;
            scl_q  <= cfg_scl;
            cs_n   <= 1'b0;
            ready  <= 1'b0;
            hcnt   <= cfg_half - 1'b1;
            ecnt   <= '0;
            state  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk <= ~sclk;
            ecnt <= enext;
            hcnt <= half_q - 1'b1;
            if (last_edge) state <= ST_TRAIL;
          end else begin
            hcnt <= hcnt - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            state <= ST_GAP;
          end else begin
            hcnt <= hcnt - 1'b1;
          end
        end
        default: begin
          if (gap_exp) begin
            done    <= 1'b1;
            ready   <= 1'b1;
            rx_word <= rx_data;
            state   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  spi_fmt_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (tx_word),
    .len       (cfg_len),
    .pre_drive (!cfg_cpha),
    .launch    (launch_now),
    .capture   (cap_sel),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data)
  );

  spi_fmt_gap #(.PRE_W(PRE_W), .SCL_W(SCL_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .pre     (pre_q),
    .scl     (scl_q),
    .expired (gap_exp)
  );

  // R1: the clock rests at the captured polarity during the idle gap
  a_r1_gap_rest_level: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> sclk == cpol_q);
  // R2: acceptance selects the peripheral and drops ready next cycle
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (!cs_n && !ready));
  // R3: half-period is at least two system clocks
  a_r3_no_fast_toggle: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$stable(sclk)) |=> $stable(sclk));
  // R3: select is released only with the clock at rest
  a_r3_release_at_rest: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> sclk == cpol_q);
  // R9: done is one cycle wide and coincides with ready rising
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_ready_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> done);
  // R10: captured configuration cannot change while busy
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(len_q) && $stable(cpha_q) && $stable(late_q)));

endmodule

// File: tb/tb_spi_fmt_master.sv
module tb_spi_fmt_master;

  localparam int MAXB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_late = 1'b0;
  logic [7:0]  cfg_half = 8'd2;
  logic [4:0]  cfg_len = 5'd8;
  logic [1:0]  cfg_pre = 2'd0;
  logic [3:0]  cfg_scl = 4'd0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic        miso = 1'b0;
  logic        ready, done, sclk, cs_n, mosi;
  logic [15:0] rx_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // monitor model state
  logic        m_cpol, m_cpha, m_late;
  int          m_half, m_len;
  logic [15:0] m_sw;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0;
  int          n_edges, bad_sp, cs_falls, idle_bad, capn, lnch;
  int          t_csf, t_csr, t_first, t_last;
  logic [15:0] got;

  spi_fmt_master dut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_late(cfg_late), .cfg_half(cfg_half), .cfg_len(cfg_len),
    .cfg_pre(cfg_pre), .cfg_scl(cfg_scl), .start(start), .tx_word(tx_word),
    .miso(miso), .ready(ready), .done(done), .rx_word(rx_word),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sbit(input int k);
    if (k < 0 || k >= m_len) return 1'b0;
    return m_sw[m_len - 1 - k];
  endfunction

  function automatic int gap_len(input int pre, input int scl);
    return (2 * pre + 1) << (scl + 1);
  endfunction

  // peripheral model and edge recorder, all at the falling system clock edge
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        t_csf = cyc; n_edges = 0; capn = 0; lnch = 0; got = '0;
        cs_falls++;
        if (m_late) miso = ~sbit(0);
        else if (!m_cpha) miso = sbit(0);
      end
      if (!prev_cs && cs_n) t_csr = cyc;
      if (!cs_n && sclk != prev_sclk) begin
        n_edges++;
        if (n_edges == 1) t_first = cyc;
        else if (cyc - t_last != m_half) bad_sp++;
        t_last = cyc;
        if (m_cpha ? (n_edges % 2 == 0) : (n_edges % 2 == 1)) begin
          got = {got[14:0], mosi};
          if (m_late) miso = sbit(capn);
          capn++;
        end else begin
          if (!m_late) miso = sbit(m_cpha ? lnch : lnch + 1);
          lnch++;
        end
      end
      if (cs_n && !ready && sclk != m_cpol) idle_bad++;
      prev_cs   = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit cpol, input bit cpha, input bit late,
                           input int half, input int len, input int pre,
                           input int scl, input logic [15:0] tx,
                           input logic [15:0] sw, input bit poke);
    logic [15:0] mask;
    int d, w;
    string fr;
    mask = 16'((32'd1 << len) - 1);
    fr   = cpha ? "R5" : "R4";
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_late = late;
    cfg_half = 8'(half); cfg_len = 5'(len); cfg_pre = 2'(pre); cfg_scl = 4'(scl);
    m_cpol = cpol; m_cpha = cpha; m_late = late; m_half = half; m_len = len; m_sw = sw;
    repeat (2) @(negedge clk);
    chk(ready && cs_n && sclk == cpol, "R1", "rest before frame",
        {ready, cs_n, sclk}, {1'b1, 1'b1, cpol});
    n_edges = 0; bad_sp = 0; cs_falls = 0; idle_bad = 0;
    start = 1'b1; tx_word = tx;
    @(negedge clk);
    start = 1'b0;
    chk(!ready && !cs_n, "R2", "accept", {ready, cs_n}, 2'b00);
    if (!cpha) chk(mosi == tx[len-1], "R4", "first bit before edge", mosi, tx[len-1]);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; tx_word = ~tx; cfg_len = 5'd4; cfg_cpha = ~cpha; cfg_late = ~late;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 150000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R9", "done seen", done, 1);
    d = cyc;
    chk(rx_word == (sw & mask), late ? "R7" : "R6", "received word", rx_word, sw & mask);
    chk(got == (tx & mask), fr, "bits on mosi", got, tx & mask);
    chk(n_edges == 2 * len, "R3", "edge count", n_edges, 2 * len);
    chk(bad_sp == 0, "R3", "edge spacing", bad_sp, 0);
    chk(t_first - t_csf == half, "R3", "select to first edge", t_first - t_csf, half);
    chk(t_csr - t_last == half, "R3", "last edge to release", t_csr - t_last, half);
    chk(d - t_csr == gap_len(pre, scl), "R8", "idle gap", d - t_csr, gap_len(pre, scl));
    chk(ready == 1'b1, "R9", "ready with done", ready, 1);
    chk(idle_bad == 0, "R1", "clock level in gap", idle_bad, 0);
    @(negedge clk);
    chk(!done && rx_word == (sw & mask), "R9", "done width / rx hold",
        {done, rx_word}, {1'b0, sw & mask});
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(cs_falls == 1 && cs_n && ready, "R10", "no extra frame",
          cs_falls, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    m_cpol = 0; m_cpha = 0; m_late = 0; m_half = 2; m_len = 8; m_sw = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready && cs_n && !done, "R1", "reset state", {ready, cs_n, done}, 3'b110);

    // all format combinations
    for (int f = 0; f < 8; f++)
      run_frame(f[0], f[1], f[2], 2, 8, 0, 0, 16'h00A5, 16'h003C, 1'b0);
    // length bounds (R6)
    run_frame(1'b0, 1'b0, 1'b0, 3, 4, 1, 1, 16'hFFF9, 16'h0006, 1'b0);
    run_frame(1'b1, 1'b1, 1'b1, 2, 16, 2, 2, 16'hC3A5, 16'h5A3C, 1'b0);
    // start while busy (R10)
    run_frame(1'b0, 1'b1, 1'b0, 4, 12, 0, 1, 16'h0ABC, 16'h0321, 1'b1);
    // random mix
    for (int i = 0; i < 24; i++)
      run_frame(1'($urandom), 1'($urandom), 1'($urandom),
                2 + int'($urandom % 3), 4 + int'($urandom % 13),
                int'($urandom % 4), int'($urandom % 4),
                16'($urandom), 16'($urandom), 1'b0);
    // long gap: codes 1 and 14 (R8)
    run_frame(1'b0, 1'b0, 1'b0, 2, 8, 1, 14, 16'h0081, 16'h0042, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule